// File: doc/BRIEF.md
# Buffered-Commit PWM Generator Group

This block drives six PWM outputs from three counter-based generators. Each generator drives two outputs. A host programs a clock divisor, a period modulus and six duty values through a small register port. Every one of those writes lands in a shadow copy. The generators keep running on their active copy until the host commits the shadows, and the commit takes effect only at a period boundary. A waveform is therefore never built from a mix of old and new settings.

The commit bit has a guard. It can be raised only when the host has read it back as zero and then writes a one. The hardware drops it once the transfer has happened. The host may also withdraw it before the boundary by writing zero.

One mode bit decides how the generators are grouped. With the bit clear, the controls of group 0 govern all three generators and all six outputs as one bank. With the bit set, each generator has its own run, commit and interrupt controls and drives only its own output pair. A per-output override lets software force any pin to a chosen level. Each group has a period-boundary flag, and that flag can raise an interrupt.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: Writes to the divisor, modulus and duty registers do not change the waveform until a commit has been taken at a period boundary.
- R2: The commit bit of group g (CTRL bit 4g+1) is set only by a CTRL write of one after a CTRL read that returned it as zero. A write of one with no such read leaves it at zero.
- R3: The commit bit clears by itself once the shadow values have been moved to the active set.
- R4: Writing zero to the commit bit before the boundary withdraws the commit, and the active values stay as they were.
- R5: After reset, CTRL reads 0, all outputs are low and irq is low.
- R6: With CTRL bit 15 clear, the group 0 controls (run bit 0, commit bit 1) drive all six outputs. With bit 15 set, group g (run bit 4g) drives only outputs 2g and 2g+1, and the other groups are unaffected.
- R7: When the run bit of an output's group is clear, the output is low, unless its override enable (OVR bit i) is set. In that case the output equals OVR bit 8+i, whatever the run state.
- R8: STAT bit g is set at every period boundary of group g and is cleared by writing one to it. irq is high exactly when some group has both its flag and its interrupt enable (CTRL bit 4g+2) set.
- R9: The 2-bit divisor field of group g (PSC bits 2g+1:2g) selects a count clock of the system clock divided by 1, 2, 4 or 8. The period is then modulus × divisor system cycles.
- R10: An output is high for min(duty, modulus) count steps in each period. A duty of 0 gives a constant low, and a duty at or above the modulus gives a constant high.
- R11: Setting the run bit in the same write as the commit bit makes the very first period use the newly committed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address (0 CTRL, 1 STAT, 2 OVR, 3 PSC, 4-6 modulus, 8-13 duty) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata one cycle later |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pwm_out | output | 6 | Registered PWM outputs |
| irq | output | 1 | Period-boundary interrupt request |

## Verification
Some properties are checked on every cycle:
- an active modulus changes only on a transfer cycle;
- the counter stays below the active modulus while running;
- the commit bit rises only after the guarded read-then-write;
- a written-one flag is clear unless a boundary coincides;
- an idle, non-overridden output is low.

Other behaviour can be shown only by the directed scenarios:
- the measured duty counts and the divisor ratios;
- that a lone write of one is ignored, and that a withdrawn commit leaves the waveform unchanged;
- the first-period result of a combined run-and-commit write;
- the way grouping mode splits the bank into pairs.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  localparam int NGRP   = 3;
  localparam int NCH    = 2 * NGRP;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_OVR  = 2;
  localparam int A_PSC  = 3;
  localparam int A_MOD0 = 4;
  localparam int A_WID0 = 8;

  // CTRL field layout: one nibble per group, grouping bit on top
  localparam int CTRL_STRIDE = 4;
  localparam int BIT_RUN     = 0;
  localparam int BIT_ARM     = 1;
  localparam int BIT_RIE     = 2;
  localparam int BIT_PAIR    = 15;
  localparam int OVR_VAL_LSB = 8;
endpackage

// File: rtl/pwm_reload_gen.sv
module pwm_reload_gen
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  arm,
  input  logic [1:0]            psc_sh,
  input  logic [CNT_W-1:0]      mod_sh,
  input  logic [1:0][CNT_W-1:0] wid_sh,
  output logic                  load,
  output logic                  reload,
  output logic [1:0]            out_raw
);
  logic                  run_q;
  logic [1:0]            psc_act;
  logic [CNT_W-1:0]      mod_act;
  logic [1:0][CNT_W-1:0] wid_act;
  logic [CNT_W-1:0]      cnt;
  logic [2:0]            pre_cnt;
  logic [2:0]            pre_lim;
  logic                  start, tick, at_end;

  assign start   = run & ~run_q;
  assign pre_lim = 3'((4'd1 << psc_act) - 4'd1);
  assign tick    = (pre_cnt == pre_lim);
  assign at_end  = ({1'b0, cnt} + 1'b1) >= {1'b0, mod_act};
  assign reload  = run & ~start & tick & at_end;
  assign load    = arm & (reload | start);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      psc_act <= '0;
      mod_act <= '1;
      wid_act <= '0;
      cnt     <= '0;
      pre_cnt <= '0;
    end else begin
      run_q <= run;
      if (load) begin
        psc_act <= psc_sh;
        mod_act <= mod_sh;
        wid_act <= wid_sh;
      end
      if (!run || start) begin
        cnt     <= '0;
        pre_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= '0;
        cnt     <= at_end ? '0 : cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_cmp
    assign out_raw[i] = run & (cnt < wid_act[i]);
  end

  // R1
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(mod_act));

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (run && mod_act != '0) |-> (cnt < mod_act));
endmodule

// File: rtl/pwm_reload_regs.sv
module pwm_reload_regs
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NGRP-1:0]               load_q,
  input  logic [NGRP-1:0]               reload_q,
  output logic [NGRP-1:0]               run,
  output logic [NGRP-1:0]               arm,
  output logic                          pair,
  output logic [NGRP-1:0][1:0]          psc_sh,
  output logic [NGRP-1:0][CNT_W-1:0]    mod_sh,
  output logic [NCH-1:0][CNT_W-1:0]     wid_sh,
  output logic [NCH-1:0]                ovr_en,
  output logic [NCH-1:0]                ovr_val,
  output logic                          irq
);
  logic [NGRP-1:0]   rie, seen, flag;
  logic              ctrl_wr, ctrl_rd, stat_wr, ovr_wr, psc_wr;
  logic [DATA_W-1:0] rd_mux;

  assign ctrl_wr = bus_wr && bus_addr == ADDR_W'(A_CTRL);
  assign ctrl_rd = bus_rd && bus_addr == ADDR_W'(A_CTRL);
  assign stat_wr = bus_wr && bus_addr == ADDR_W'(A_STAT);
  assign ovr_wr  = bus_wr && bus_addr == ADDR_W'(A_OVR);
  assign psc_wr  = bus_wr && bus_addr == ADDR_W'(A_PSC);

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) begin
      for (int g = 0; g < NGRP; g++) begin
        rd_mux[g*CTRL_STRIDE+BIT_RUN] = run[g];
        rd_mux[g*CTRL_STRIDE+BIT_ARM] = arm[g];
        rd_mux[g*CTRL_STRIDE+BIT_RIE] = rie[g];
      end
      rd_mux[BIT_PAIR] = pair;
    end
    if (bus_addr == ADDR_W'(A_STAT)) rd_mux[NGRP-1:0] = flag;
    if (bus_addr == ADDR_W'(A_OVR)) begin
      rd_mux[NCH-1:0]                     = ovr_en;
      rd_mux[OVR_VAL_LSB +: NCH]          = ovr_val;
    end
    if (bus_addr == ADDR_W'(A_PSC)) rd_mux[2*NGRP-1:0] = psc_sh;
    for (int g = 0; g < NGRP; g++)
      if (bus_addr == ADDR_W'(A_MOD0 + g)) rd_mux[CNT_W-1:0] = mod_sh[g];
    for (int i = 0; i < NCH; i++)
      if (bus_addr == ADDR_W'(A_WID0 + i)) rd_mux[CNT_W-1:0] = wid_sh[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0; arm <= '0; rie <= '0; seen <= '0; flag <= '0;
      pair <= 1'b0; psc_sh <= '0; mod_sh <= '0; wid_sh <= '0;
      ovr_en <= '0; ovr_val <= '0; irq <= 1'b0; bus_rdata <= '0;
    end else begin
      for (int g = 0; g < NGRP; g++) begin
        if (ctrl_wr) begin
          run[g] <= bus_wdata[g*CTRL_STRIDE+BIT_RUN];
          rie[g] <= bus_wdata[g*CTRL_STRIDE+BIT_RIE];
          arm[g] <= bus_wdata[g*CTRL_STRIDE+BIT_ARM] & (seen[g] | (arm[g] & ~load_q[g]));
        end else if (load_q[g]) begin
          arm[g] <= 1'b0;
        end
        if (ctrl_rd)      seen[g] <= ~arm[g];
        else if (ctrl_wr) seen[g] <= 1'b0;
        if (reload_q[g])                    flag[g] <= 1'b1;
        else if (stat_wr && bus_wdata[g])   flag[g] <= 1'b0;
        if (psc_wr) psc_sh[g] <= bus_wdata[2*g +: 2];
        if (bus_wr && bus_addr == ADDR_W'(A_MOD0 + g)) mod_sh[g] <= bus_wdata[CNT_W-1:0];
      end
      for (int i = 0; i < NCH; i++)
        if (bus_wr && bus_addr == ADDR_W'(A_WID0 + i)) wid_sh[i] <= bus_wdata[CNT_W-1:0];
      if (ctrl_wr) pair <= bus_wdata[BIT_PAIR];
      if (ovr_wr) begin
        ovr_en  <= bus_wdata[NCH-1:0];
        ovr_val <= bus_wdata[OVR_VAL_LSB +: NCH];
      end
      irq <= |(flag & rie);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R2
    arm_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(arm[g]) |-> $past(ctrl_wr && seen[g]));
    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
      $past(stat_wr && bus_wdata[g] && !reload_q[g]) |-> !flag[g]);
  end
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [5:0]        pwm_out,
  output logic              irq
);
  logic [NGRP-1:0]            run, arm, run_e, arm_e, own, load, reload;
  logic                       pair;
  logic [NGRP-1:0][1:0]       psc_sh;
  logic [NGRP-1:0][CNT_W-1:0] mod_sh;
  logic [NCH-1:0][CNT_W-1:0]  wid_sh;
  logic [NCH-1:0]             ovr_en, ovr_val, raw;

  pwm_reload_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .load_q(load & own), .reload_q(reload & own),
    .run(run), .arm(arm), .pair(pair),
    .psc_sh(psc_sh), .mod_sh(mod_sh), .wid_sh(wid_sh),
    .ovr_en(ovr_en), .ovr_val(ovr_val), .irq(irq)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_gen
    logic [1:0]       psc_e;
    logic [CNT_W-1:0] mod_e;
    assign own[g]   = pair | (g == 0);
    assign run_e[g] = pair ? run[g] : run[0];
    assign arm_e[g] = pair ? arm[g] : arm[0];
    assign psc_e    = pair ? psc_sh[g] : psc_sh[0];
    assign mod_e    = pair ? mod_sh[g] : mod_sh[0];

    pwm_reload_gen #(.CNT_W(CNT_W)) u_gen (
      .clk(clk), .rst(rst),
      .run(run_e[g]), .arm(arm_e[g]),
      .psc_sh(psc_e), .mod_sh(mod_e), .wid_sh(wid_sh[2*g +: 2]),
      .load(load[g]), .reload(reload[g]),
      .out_raw(raw[2*g +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= '0;
    else
      for (int i = 0; i < NCH; i++)
        pwm_out[i] <= ovr_en[i] ? ovr_val[i] : raw[i];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_idle
    // R7
    out_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!run_e[i/2] && !ovr_en[i]) |-> !pwm_out[i]);
  end
endmodule

// File: tb/pwm_reload_ctrl_bench.sv
module pwm_reload_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [5:0]  pwm_out;
  logic        irq;
  int nchk = 0, nfail = 0;
  int hi [6];
  logic [15:0] d;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_reload_ctrl u_pwm_reload_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk); bus_addr = a[3:0]; bus_wdata = v[15:0]; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk); bus_addr = a[3:0]; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic measure(input int skip, input int n);
    repeat (skip) @(negedge clk);
    for (int i = 0; i < 6; i++) hi[i] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < 6; i++) if (pwm_out[i]) hi[i]++;
    end
  endtask

  function automatic int exp_hi(input int w, input int m, input int div, input int n);
    return (w < m ? w : m) * div * (n / (m * div));
  endfunction

  task automatic t_reset;
    rd(0, d);
    chk("R5 ctrl", d, 0);
    chk("R5 out", pwm_out, 0);
    chk("R5 irq", irq, 0);
  endtask

  task automatic t_first_period;
    wr(4, 8); wr(8, 5); wr(9, 8); wr(10, 0); wr(11, 3); wr(12, 2); wr(13, 2);
    rd(0, d);
    wr(0, 16'h0003);                       // run0 + commit0 together
    measure(2, 8);
    chk("R11 out0", hi[0], exp_hi(5, 8, 1, 8));
    chk("R10 out1 full", hi[1], 8);
    chk("R10 out2 zero", hi[2], 0);
    chk("R6 out3 bank", hi[3], exp_hi(3, 8, 1, 8));
  endtask

  task automatic t_lone_write;
    wr(8, 2);
    wr(0, 16'h0003);                       // no read-as-zero before
    rd(0, d);
    chk("R2 arm", d[1], 0);
    measure(20, 8);
    chk("R2 out0", hi[0], 5);
  endtask

  task automatic t_commit;
    wr(0, 16'h0003);                       // after read-as-zero
    repeat (20) @(negedge clk);
    rd(0, d);
    chk("R3 arm clr", d[1], 0);
    measure(0, 16);
    chk("R1 out0", hi[0], exp_hi(2, 8, 1, 16));
  endtask

  task automatic t_cancel;
    wr(0, 0);
    wr(8, 6);
    rd(0, d);
    wr(0, 16'h0002);
    wr(0, 16'h0000);                       // withdraw
    wr(0, 16'h0001);
    measure(20, 16);
    chk("R4 out0", hi[0], exp_hi(2, 8, 1, 16));
  endtask

  task automatic t_prescale;
    wr(0, 0); wr(3, 2); wr(4, 5); wr(8, 2);
    rd(0, d); wr(0, 16'h0003);
    measure(10, 40);
    chk("R9 div4", hi[0], exp_hi(2, 5, 4, 40));
    wr(0, 0); wr(3, 3); wr(4, 3); wr(8, 1);
    rd(0, d); wr(0, 16'h0003);
    measure(10, 48);
    chk("R9 div8", hi[0], exp_hi(1, 3, 8, 48));
  endtask

  task automatic t_irq;
    rd(1, d);
    chk("R8 flag", d[0], 1);
    chk("R8 irq off", irq, 0);
    wr(0, 16'h0005);
    repeat (2) @(negedge clk);
    chk("R8 irq on", irq, 1);
    wr(0, 16'h0004);
    wr(1, 1);
    repeat (2) @(negedge clk);
    chk("R8 irq clr", irq, 0);
    rd(1, d);
    chk("R8 flag clr", d[0], 0);
    wr(0, 0);
  endtask

  task automatic t_override;
    wr(2, 16'h0203);                       // en out0/out1, value out1=1
    measure(2, 8);
    chk("R7 out0", hi[0], 0);
    chk("R7 out1", hi[1], 8);
    chk("R7 out2", hi[2], 0);
    wr(2, 0);
  endtask

  task automatic t_pair;
    wr(0, 16'h8000);
    wr(3, 0); wr(5, 4); wr(10, 1); wr(11, 4);
    rd(0, d);
    wr(0, 16'h8030);                       // pair + run1 + commit1
    measure(3, 8);
    chk("R6 out2", hi[2], exp_hi(1, 4, 1, 8));
    chk("R6 out3", hi[3], 8);
    chk("R6 out0 idle", hi[0], 0);
    chk("R6 out4 idle", hi[4], 0);
    rd(1, d);
    chk("R6 flag1", d[2:0], 3'b010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_period();
    t_lone_write();
    t_commit();
    t_cancel();
    t_prescale();
    t_irq();
    t_override();
    t_pair();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule